// File: doc/BRIEF.md
# Supply Voltage Monitor Controller

This block is the digital side of a supply-voltage monitor. Two analog comparators sit outside it. The first reports that the internal supply has fallen below its threshold. The second reports that an external sense pin has fallen below its own threshold. Both arrive as asynchronous levels, active high for "below". Each level is synchronized by two flops and then glitch-filtered. A small control register then picks one source and one of two reactions.

In reset mode the block holds a reset request for as long as the chosen source sits below its threshold. The request drops as soon as the source is back at or above the threshold. In interrupt mode the block emits a one-clock pulse on every crossing, both going below and coming back. A read-only flag in the same register shows the chosen source's present state.

A configuration input sampled during power-on reset decides whether the monitor starts enabled. After reset it is always in reset mode, watching the internal supply.

Top module: `volt_mon`

## Requirements
- R1: While `rst_ni` is low, the control register loads enable = `dflt_en_i`, mode = 1 and source = 0. With both sources above threshold, `ctrl_rdata_o` then reads 8'h82 when `dflt_en_i` was 1 and 8'h02 when it was 0.
- R2: Control bit 1 is the mode: 1 selects reset generation and 0 selects interrupt generation. A write takes effect on the clock edge that samples `ctrl_we_i`.
- R3: Control bit 2 is the source: 0 selects the internal supply comparator (`vdd_low_i`) and 1 selects the external pin comparator (`ext_low_i`).
- R4: Control bit 0 is a read-only flag equal to enable AND the filtered below-state of the selected source. Writing it has no effect. Bits 6..3 read 0.
- R5: In reset mode with enable set, `rst_req_o` is high exactly while the selected filtered source is below threshold, and `irq_o` stays low.
- R6: In interrupt mode with enable set, `irq_o` gives exactly one single-cycle pulse per crossing of the selected filtered source, in either direction, and `rst_req_o` stays low.
- R7: A below level is accepted only after FILT_CYCLES consecutive synchronized below samples; default FILT_CYCLES = 4. A return to above is accepted on the first above sample. A shorter below glitch causes no flag, no reset and no interrupt.
- R8: Writing new source, mode or enable values never produces an interrupt pulse, even when the newly selected level differs from the old one.
- R9: Control bit 7 is the enable. While it is 0, the flag reads 0 and both `rst_req_o` and `irq_o` stay low.
- R10: Activity on the unselected comparator has no effect on the flag, `rst_req_o` or `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| dflt_en_i | input | 1 | Non-volatile default enable, sampled during reset |
| vdd_low_i | input | 1 | Asynchronous internal-supply comparator, 1 = below threshold |
| ext_low_i | input | 1 | Asynchronous external-pin comparator, 1 = below threshold |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_rdata_o | output | 8 | Control register read data {en,0000,src,mode,flag} |
| rst_req_o | output | 1 | Internal reset request (reset mode) |
| irq_o | output | 1 | One-cycle interrupt pulse (interrupt mode) |

## Verification
The bench switches the source and the mode while the two comparators disagree. An edge detector that is not re-armed on a configuration change would emit a stray pulse, and the pulse scoreboard would count it. Below-threshold glitches shorter than the filter window are injected; an unfiltered design would let the reset request or the flag blink during them. Crossings are toggled in both directions in interrupt mode, so a detector that saw only one edge, or made a pulse longer than one cycle, shows up in the count or the width check. Each source is also toggled while the other is selected, and while enable is clear, to expose any leakage through the source mux or the enable gate.

// File: rtl/vmon_pkg.sv
package vmon_pkg;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_VDD = 0;
  localparam int unsigned SRC_EXT = 1;

  localparam int unsigned BIT_FLAG = 0;
  localparam int unsigned BIT_MODE = 1;
  localparam int unsigned BIT_SRC  = 2;
  localparam int unsigned BIT_EN   = 7;

  typedef enum logic {
    MODE_IRQ = 1'b0,
    MODE_RST = 1'b1
  } vmon_mode_e;

  typedef struct packed {
    logic       en;
    logic       src;
    vmon_mode_e mode;
  } vmon_cfg_t;
endpackage

// File: rtl/vmon_sync.sv
module vmon_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/vmon_filter.sv
module vmon_filter #(
  parameter int unsigned FILT_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic below_i,
  output logic below_o
);
  localparam int unsigned CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (!below_i) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (!filt_q) begin
      if (cnt_q == LAST) filt_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign below_o = filt_q;

  // R7: acceptance needs a below sample in the cycle before
  assert_filt_below_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(below_o) |-> $past(below_i));
  // R7: return to above on first above sample
  assert_filt_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !below_i |=> !below_o);
endmodule

// File: rtl/vmon_ctrl_regs.sv
module vmon_ctrl_regs
  import vmon_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      dflt_en_i,
  input  logic      we_i,
  input  logic [7:0] wdata_i,
  input  logic      flag_i,
  output vmon_cfg_t cfg_o,
  output logic [7:0] rdata_o
);
  vmon_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.en   <= dflt_en_i;
      cfg_q.src  <= 1'b0;
      cfg_q.mode <= MODE_RST;
    end else if (we_i) begin
      cfg_q.en   <= wdata_i[BIT_EN];
      cfg_q.src  <= wdata_i[BIT_SRC];
      cfg_q.mode <= vmon_mode_e'(wdata_i[BIT_MODE]);
    end
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[BIT_EN]   = cfg_q.en;
    rdata_o[BIT_SRC]  = cfg_q.src;
    rdata_o[BIT_MODE] = cfg_q.mode;
    rdata_o[BIT_FLAG] = flag_i;
  end

  assign cfg_o = cfg_q;

  // R2: a write lands on the sampling edge
  assert_mode_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o[BIT_MODE] == $past(wdata_i[BIT_MODE])));
  // R3
  assert_src_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o[BIT_SRC] == $past(wdata_i[BIT_SRC])));
  // R1: config holds without a write
  assert_cfg_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_o));
endmodule

// File: rtl/volt_mon.sv
module volt_mon
  import vmon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dflt_en_i,
  input  logic       vdd_low_i,
  input  logic       ext_low_i,
  input  logic       ctrl_we_i,
  input  logic [7:0] ctrl_wdata_i,
  output logic [7:0] ctrl_rdata_o,
  output logic       rst_req_o,
  output logic       irq_o
);
  logic [NUM_SRC-1:0] raw_low, sync_low, filt_low;
  vmon_cfg_t cfg, cfg_q;
  logic      sel_low, prev_q, armed, flag;

  assign raw_low[SRC_VDD] = vdd_low_i;
  assign raw_low[SRC_EXT] = ext_low_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chan
    vmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_low[g]),
      .q_o   (sync_low[g])
    );
    vmon_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .below_i(sync_low[g]),
      .below_o(filt_low[g])
    );
  end

  vmon_ctrl_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dflt_en_i(dflt_en_i),
    .we_i     (ctrl_we_i),
    .wdata_i  (ctrl_wdata_i),
    .flag_i   (flag),
    .cfg_o    (cfg),
    .rdata_o  (ctrl_rdata_o)
  );

  assign sel_low = filt_low[cfg.src];

  // Previous level always tracks; a config change disarms for one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cfg_q  <= '{en: 1'b0, src: 1'b0, mode: MODE_RST};
    end else begin
      prev_q <= sel_low;
      cfg_q  <= cfg;
    end
  end

  assign armed     = (cfg == cfg_q);
  assign flag      = cfg.en & sel_low;
  assign rst_req_o = flag & (cfg.mode == MODE_RST);
  assign irq_o     = cfg.en & (cfg.mode == MODE_IRQ) & armed & (sel_low ^ prev_q);

  // R5
  assert_rst_only_mode_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (ctrl_rdata_o[BIT_EN] && ctrl_rdata_o[BIT_MODE] && ctrl_rdata_o[BIT_FLAG]));
  // R6
  assert_irq_only_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!ctrl_rdata_o[BIT_MODE] && !rst_req_o));
  assert_irq_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R8
  assert_no_cfg_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> !irq_o);
  // R9
  assert_disabled_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rdata_o[BIT_EN] |-> (!ctrl_rdata_o[BIT_FLAG] && !rst_req_o && !irq_o));
  // R4
  assert_pad_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[6:3] == 4'b0);
endmodule

// File: tb/volt_mon_test.sv
module volt_mon_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dflt_en_i = 1'b1;
  logic       vdd_low_i = 1'b0;
  logic       ext_low_i = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [7:0] ctrl_wdata_i = '0;
  logic [7:0] ctrl_rdata_o;
  logic       rst_req_o, irq_o;

  int vectors = 0;
  int errors  = 0;
  int irq_seen = 0;
  logic irq_last = 1'b0;
  int   exp_q[$];
  string tag_q[$];
  bit   done = 1'b0;

  always #4 clk_i = ~clk_i;

  volt_mon uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .dflt_en_i(dflt_en_i),
    .vdd_low_i(vdd_low_i), .ext_low_i(ext_low_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
    .ctrl_rdata_o(ctrl_rdata_o), .rst_req_o(rst_req_o), .irq_o(irq_o)
  );

  // Monitor: counts pulses, checks width (R6)
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (irq_o) irq_seen++;
      if (irq_o && irq_last) begin
        errors++;
        $display("FAIL R6 irq width: actual 2+ cycles expected 1");
      end
      irq_last = irq_o;
    end
  end

  // Scoreboard: pops expected pulse counts
  initial begin
    forever begin
      wait (exp_q.size() > 0);
      begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if (irq_seen != e) begin
          errors++;
          $display("FAIL %s irq count: actual %0d expected %0d", t, irq_seen, e);
        end
        irq_seen = 0;
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic push_irq(int n, string t);
    exp_q.push_back(n);
    tag_q.push_back(t);
    #1;
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk_i);
    ctrl_we_i    = 1'b1;
    ctrl_wdata_i = d;
    @(negedge clk_i);
    ctrl_we_i    = 1'b0;
  endtask

  task automatic chk(string t, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic chk_out(string t, logic [7:0] rd, logic rr);
    chk({t, " rdata"}, ctrl_rdata_o, rd);
    chk({t, " rst_req"}, {7'b0, rst_req_o}, {7'b0, rr});
  endtask

  task automatic do_reset(logic dflt);
    rst_ni    = 1'b0;
    dflt_en_i = dflt;
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    irq_seen = 0;
  endtask

  initial begin
    fork
      begin
        tick(20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    join_none

    // R1 reset default enabled
    do_reset(1'b1);
    chk_out("R1 dflt_en=1", 8'h82, 1'b0);

    // R5 reset mode on internal supply
    vdd_low_i = 1'b1; tick(20);
    chk_out("R5 below", 8'h83, 1'b1);
    vdd_low_i = 1'b0; tick(20);
    chk_out("R5 release", 8'h82, 1'b0);
    push_irq(0, "R5 no irq in reset mode");

    // R7 glitch of 2 cycles, never asserted
    begin
      int hits = 0;
      vdd_low_i = 1'b1; tick(2); vdd_low_i = 1'b0;
      for (int i = 0; i < 15; i++) begin
        tick(1);
        if (rst_req_o || ctrl_rdata_o[0]) hits++;
      end
      chk("R7 glitch filtered", 8'(hits), 8'd0);
    end
    // R7 long below is accepted
    vdd_low_i = 1'b1; tick(12);
    chk_out("R7 stable below", 8'h83, 1'b1);
    vdd_low_i = 1'b0; tick(12);

    // R10 unselected external pin ignored
    ext_low_i = 1'b1; tick(20);
    chk_out("R10 ext ignored", 8'h82, 1'b0);
    // R3 switch to external source in reset mode
    wr(8'h86); tick(2);
    chk_out("R3 ext selected", 8'h87, 1'b1);
    ext_low_i = 1'b0; tick(20);
    chk_out("R3 ext released", 8'h86, 1'b0);
    push_irq(0, "R3 no irq");

    // R6 interrupt mode on external pin, both crossings
    wr(8'h84); tick(2);
    ext_low_i = 1'b1; tick(20);
    chk_out("R6 ext below flag", 8'h85, 1'b0);
    ext_low_i = 1'b0; tick(20);
    push_irq(2, "R6 ext two crossings");
    vdd_low_i = 1'b1; tick(20); vdd_low_i = 1'b0; tick(20);
    push_irq(0, "R10 vdd ignored in irq mode");

    // R6 on internal supply, count per crossing
    wr(8'h80); tick(2);
    vdd_low_i = 1'b1; tick(20);
    chk_out("R6 vdd below", 8'h81, 1'b0);
    push_irq(1, "R6 falling crossing");
    vdd_low_i = 1'b0; tick(20);
    push_irq(1, "R6 rising crossing");

    // R8 config changes with disagreeing levels (vdd below, ext above)
    vdd_low_i = 1'b1; tick(20);
    push_irq(1, "R8 setup");
    wr(8'h84); tick(3);
    wr(8'h80); tick(3);
    wr(8'h00); tick(3);
    wr(8'h80); tick(3);
    wr(8'h82); tick(3);
    chk_out("R2 reset mode on write", 8'h83, 1'b1);
    wr(8'h80); tick(3);
    push_irq(0, "R8 no spurious irq");

    // R9 disabled: flag 0, no reset, no irq
    wr(8'h02); tick(3);
    chk_out("R9 disabled reset mode", 8'h02, 1'b0);
    vdd_low_i = 1'b0; tick(20); vdd_low_i = 1'b1; tick(20);
    wr(8'h00); tick(2);
    vdd_low_i = 1'b0; tick(20);
    chk_out("R9 disabled irq mode", 8'h00, 1'b0);
    push_irq(0, "R9 no irq while disabled");

    // R4 flag bit not writable
    wr(8'h81); tick(3);
    chk_out("R4 flag write ignored", 8'h80, 1'b0);
    push_irq(0, "R4 no irq");

    // R1 reset default disabled
    do_reset(1'b0);
    vdd_low_i = 1'b1; tick(20);
    chk_out("R1 dflt_en=0", 8'h02, 1'b0);
    vdd_low_i = 1'b0; tick(20);

    wait (exp_q.size() == 0);
    tick(1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule